// File: doc/BRIEF.md
# Deduplicating Sorted Stream Merger

This block takes two streams of unsigned integers, each arriving in strictly increasing order, and produces one strictly increasing output stream that is the set union of the two. A value that appears in both inputs leaves the block only once. All three sides use a valid/ready handshake, so either input or the output may stall at any time.

Internally the block keeps one head register per input and compares the two heads. When the heads differ, the smaller one is emitted and only that input is refilled. When they are equal, the value is emitted once and both inputs are refilled. Reads are blocking. The block never emits anything while either head is empty, and it does not move ahead on the other input when one input runs dry. The output sequence therefore depends only on the input sequences, not on their arrival timing. A stream that ends should be closed with a common terminating value on both inputs, so that every real value is flushed out.

The output is held in a register. The heads refill in the same cycle their value moves into that register. With both inputs and the output running without stalls, the block sustains one output per clock.

Top module: `sorted_union_merge`

## Requirements
- R1: A synchronous active-high reset empties both head registers and clears `m_valid`. After reset, `a_ready` and `b_ready` are both high.
- R2: No value is emitted until both heads hold a value. If only one input has delivered, the block holds that head, keeps `m_valid` low and drives that input's ready low.
- R3: When the two heads differ, the smaller value is emitted and only the input that supplied it is refilled. The larger head stays in place.
- R4: When the two heads are equal, that value is emitted exactly once and both inputs are refilled.
- R5: For strictly increasing inputs, the output is the strictly increasing union of both input sequences, with nothing lost, repeated or added.
- R6: An output transfer happens only on a clock edge where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` hold their values.
- R7: A head accepts a new input value when it is empty or when its value is consumed in the same cycle. A full head whose value is not being consumed holds its input's ready low. With both inputs always valid and `m_ready` always high, one value is transferred out on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | First input stream holds a value |
| a_ready | output | 1 | Block accepts a value on the first input |
| a_data | input | W | First input value |
| b_valid | input | 1 | Second input stream holds a value |
| b_ready | output | 1 | Block accepts a value on the second input |
| b_data | input | W | Second input value |
| m_valid | output | 1 | Output value present |
| m_ready | input | 1 | Consumer accepts the output value |
| m_data | output | W | Merged output value |

## Verification
The ascending-order property assumes that each input is strictly increasing, and that consecutive runs are separated by a reset, since each run ends on the all-ones terminator. The bench builds every input sequence in ascending order and closes it with that terminator on both inputs. It resets the block before each run. Stimulus drops input valid and output ready at random, and it covers overlapping, identical, fully separated and interleaved streams. Each run's expected union is computed by the bench and checked value by value as tokens leave the block.

// File: rtl/smerge_pkg.sv
package smerge_pkg;
  // which head(s) feed the current output decision
  typedef enum logic [1:0] {
    PICK_NONE = 2'b00,
    PICK_A    = 2'b01,
    PICK_B    = 2'b10,
    PICK_BOTH = 2'b11
  } pick_e;
endpackage

// File: rtl/smerge_head.sv
// One-entry head register for an input stream (R7).
module smerge_head #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  logic         hv_q;
  logic [W-1:0] hd_q;

  assign in_ready   = !hv_q || pop;
  assign head_valid = hv_q;
  assign head_data  = hd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hv_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      hv_q <= 1'b1;
    end else if (pop) begin
      hv_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      hd_q <= in_data;
    end
  end
endmodule

// File: rtl/smerge_pick.sv
// Compares the heads and decides what to emit and which heads to consume.
module smerge_pick
  import smerge_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         a_v,
  input  logic [W-1:0] a_d,
  input  logic         b_v,
  input  logic [W-1:0] b_d,
  input  logic         slot_free,
  output logic         load,
  output logic [W-1:0] load_data,
  output logic         pop_a,
  output logic         pop_b
);
  pick_e pick;

  always_comb begin
    pick = PICK_NONE;
    if (a_v && b_v && slot_free) begin
      if (a_d < b_d) begin
        pick = PICK_A;
      end else if (b_d < a_d) begin
        pick = PICK_B;
      end else begin
        pick = PICK_BOTH;
      end
    end
  end

  assign load      = (pick != PICK_NONE);
  assign load_data = (pick == PICK_B) ? b_d : a_d;
  assign pop_a     = (pick == PICK_A) || (pick == PICK_BOTH);
  assign pop_b     = (pick == PICK_B) || (pick == PICK_BOTH);
endmodule

// File: rtl/smerge_outreg.sv
// Registered output stage with valid/ready.
module smerge_outreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         slot_free,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign slot_free = !v_q || m_ready;
  assign m_valid   = v_q;
  assign m_data    = d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
    end else if (load) begin
      v_q <= 1'b1;
    end else if (m_ready) begin
      v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      d_q <= load_data;
    end
  end
endmodule

// File: rtl/sorted_union_merge.sv
module sorted_union_merge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_valid,
  output logic         a_ready,
  input  logic [W-1:0] a_data,
  input  logic         b_valid,
  output logic         b_ready,
  input  logic [W-1:0] b_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]         src_valid;
  logic [NSRC-1:0]         src_ready;
  logic [NSRC-1:0][W-1:0]  src_data;
  logic [NSRC-1:0]         head_v;
  logic [NSRC-1:0][W-1:0]  head_d;
  logic [NSRC-1:0]         pop;
  logic                    slot_free;
  logic                    load;
  logic [W-1:0]            load_data;

  assign src_valid = {b_valid, a_valid};
  assign src_data  = {b_data, a_data};
  assign a_ready   = src_ready[0];
  assign b_ready   = src_ready[1];

  for (genvar g = 0; g < NSRC; g++) begin : g_head
    smerge_head #(.W(W)) u_head (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (src_valid[g]),
      .in_ready   (src_ready[g]),
      .in_data    (src_data[g]),
      .pop        (pop[g]),
      .head_valid (head_v[g]),
      .head_data  (head_d[g])
    );
  end

  smerge_pick #(.W(W)) u_pick (
    .a_v       (head_v[0]),
    .a_d       (head_d[0]),
    .b_v       (head_v[1]),
    .b_d       (head_d[1]),
    .slot_free (slot_free),
    .load      (load),
    .load_data (load_data),
    .pop_a     (pop[0]),
    .pop_b     (pop[1])
  );

  smerge_outreg #(.W(W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (load_data),
    .slot_free (slot_free),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data)
  );
endmodule

// File: rtl/smerge_checks.sv
module smerge_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         a_ready,
  input logic         b_ready,
  input logic         m_valid,
  input logic         m_ready,
  input logic [W-1:0] m_data,
  input logic [1:0]   head_v
);
  logic         have_q;
  logic [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q <= 1'b0;
    end else if (m_valid && m_ready) begin
      have_q <= 1'b1;
      last_q <= m_data;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!m_valid && a_ready && b_ready));

  // R2
  a_r2_needs_both: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $past(head_v == 2'b11));

  // R5
  a_r5_ascending: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && have_q) |-> (m_data > last_q));

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R7
  a_r7_full_a: assert property (@(posedge clk) disable iff (rst)
    (head_v[0] && m_valid && !m_ready) |-> !a_ready);

  a_r7_full_b: assert property (@(posedge clk) disable iff (rst)
    (head_v[1] && m_valid && !m_ready) |-> !b_ready);
endmodule

bind sorted_union_merge smerge_checks #(.W(W)) u_checks (
  .clk     (clk),
  .rst     (rst),
  .a_ready (a_ready),
  .b_ready (b_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .head_v  (head_v)
);

// File: tb/tb_sorted_union_merge.sv
module tb_sorted_union_merge;
  localparam int W = 16;
  localparam int TERM = 16'hFFFF;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         a_valid = 1'b0;
  logic [W-1:0] a_data = '0;
  logic         b_valid = 1'b0;
  logic [W-1:0] b_data = '0;
  logic         m_ready = 1'b0;
  logic         a_ready, b_ready, m_valid;
  logic [W-1:0] m_data;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  int    rdy_pct = 100;
  bit    b2b = 1'b0;
  bit    have_prev = 1'b0;
  int    prev_cyc = 0;
  string cur_tag = "R5";
  bit    done = 1'b0;
  int    qa[$];
  int    qb[$];
  int    exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sorted_union_merge #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: drives m_ready, pops the scoreboard on each output transfer
  always begin
    @(negedge clk);
    m_ready = (rdy_pct >= 100) ? 1'b1 : (int'($urandom_range(0, 99)) < rdy_pct);
    #2;
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected output", int'(m_data), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(m_data) == e, cur_tag, int'(m_data), e);
        if (b2b && have_prev)
          check(cyc == prev_cyc + 1, "R7 back-to-back gap", cyc - prev_cyc, 1);
        have_prev = 1'b1;
        prev_cyc  = cyc;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_valid = 1'b0; b_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    have_prev = 1'b0;
  endtask

  // builds both streams and pushes the expected union into the scoreboard
  task automatic build(input int mode);
    int i, j;
    qa.delete(); qb.delete();
    for (int v = 1; v <= 60; v++) begin
      case (mode)
        0: begin
          if ($urandom_range(0, 99) < 45) qa.push_back(v);
          if ($urandom_range(0, 99) < 45) qb.push_back(v);
        end
        1: if (v % 2 == 0) begin qa.push_back(v); qb.push_back(v); end
        2: begin
          if (v <= 20) qa.push_back(v);
          if (v > 40) qb.push_back(v + 100);
        end
        default: if (v % 2 == 0) qa.push_back(v); else qb.push_back(v);
      endcase
    end
    qa.push_back(TERM); qb.push_back(TERM);
    i = 0; j = 0;
    while (i < qa.size() || j < qb.size()) begin
      if (j >= qb.size() || (i < qa.size() && qa[i] < qb[j])) begin
        exp_q.push_back(qa[i]); i++;
      end else if (i >= qa.size() || qb[j] < qa[i]) begin
        exp_q.push_back(qb[j]); j++;
      end else begin
        exp_q.push_back(qa[i]); i++; j++;
      end
    end
  endtask

  task automatic drive_a(input int pct);
    int i = 0;
    while (i < qa.size()) begin
      @(negedge clk);
      if (int'($urandom_range(0, 99)) < pct) begin
        a_valid = 1'b1; a_data = W'(qa[i]);
        #2;
        if (a_ready) i++;
      end else begin
        a_valid = 1'b0;
      end
    end
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic drive_b(input int pct);
    int i = 0;
    while (i < qb.size()) begin
      @(negedge clk);
      if (int'($urandom_range(0, 99)) < pct) begin
        b_valid = 1'b1; b_data = W'(qb[i]);
        #2;
        if (b_ready) i++;
      end else begin
        b_valid = 1'b0;
      end
    end
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic send_a(input int v);
    @(negedge clk);
    a_valid = 1'b1; a_data = W'(v);
    #2;
    while (!a_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    a_valid = 1'b0;
  endtask

  task automatic send_b(input int v);
    @(negedge clk);
    b_valid = 1'b1; b_data = W'(v);
    #2;
    while (!b_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    repeat (3) @(negedge clk);
    #2;
    check(!m_valid && a_ready && b_ready, "R2 idle after drain",
          {m_valid, a_ready, b_ready}, 3);
  endtask

  task automatic run(input int mode, input int vpct, input int rpct,
                     input bit bb, input string tag);
    do_reset();
    rdy_pct = rpct; b2b = bb; cur_tag = tag;
    build(mode);
    fork
      drive_a(vpct);
      drive_b(vpct);
    join
    drain(tag);
    b2b = 1'b0;
  endtask

  initial begin
    // R1: reset state
    rdy_pct = 100;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    check(!m_valid, "R1 m_valid after reset", m_valid, 0);
    check(a_ready && b_ready, "R1 readies after reset", {a_ready, b_ready}, 3);

    // R2: a lone head stalls; R4: equal heads give one output
    cur_tag = "R4 equal heads";
    send_a(5);
    repeat (5) @(negedge clk);
    #2;
    check(!m_valid, "R2 no output with one head", m_valid, 0);
    check(!a_ready, "R2 full head holds ready low", a_ready, 0);
    check(b_ready, "R2 empty head stays ready", b_ready, 1);
    exp_q.push_back(5);
    send_b(5);
    drain("R4 equal heads");

    // R1: reset while a head is loaded
    send_a(9);
    do_reset();
    @(negedge clk); #2;
    check(a_ready && !m_valid, "R1 reset empties head", {a_ready, m_valid}, 2);

    // R6: output held under back-pressure; R3 smaller head first
    rdy_pct = 0; cur_tag = "R3 smaller first";
    send_a(3);
    send_b(7);
    repeat (3) @(negedge clk);
    #2;
    check(m_valid && m_data == 3, "R6 held output", int'(m_data), 3);
    check(a_ready && !b_ready, "R3 only used head refills", {a_ready, b_ready}, 2);
    repeat (4) @(negedge clk);
    #2;
    check(m_valid && m_data == 3, "R6 stable while stalled", int'(m_data), 3);
    exp_q.push_back(3); exp_q.push_back(7);
    rdy_pct = 100;
    send_a(7);
    drain("R6 release");

    // streaming scenarios
    run(0, 70, 70, 1'b0, "R5 random overlap");
    run(0, 100, 40, 1'b0, "R5 output back-pressure");
    run(1, 100, 100, 1'b1, "R4 identical streams");
    run(2, 60, 80, 1'b0, "R3 separated ranges");
    run(3, 100, 100, 1'b1, "R7 interleaved full rate");
    run(0, 100, 100, 1'b1, "R7 overlap full rate");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule